// File: doc/BRIEF.md
# Asynchronous Byte-Wide SRAM Cycle Sequencer

This block sits between a synchronous host and a common-I/O static RAM of 256K bytes. It turns one host request at a time into the active-low chip-enable, write-enable and output-enable strobes that such a RAM expects. All cycle phases are whole clock periods whose lengths are set by parameters. Every memory-side output comes straight from a flop, so the strobe edges carry no combinational glitches.

The host offers a request with `req_valid` while `req_ready` is high. The request carries an 18-bit address, a write flag and 8 bits of write data. The sequencer first presents the address for one setup cycle. It then opens a read window or a write pulse, and closes with a recovery phase before it takes the next request. A read returns its byte on `rsp_rdata` with a one-cycle `rsp_valid` pulse. A write is also acknowledged with `rsp_valid`. A supervisor can raise `write_protect`. A write accepted while that input is high is answered at once with `rsp_error`, and the memory sees no cycle at all.

Top module: `sram_seq`

## Requirements
- R1: While reset is high and in the first cycle after it, `mem_ce_n`, `mem_we_n` and `mem_oe_n` are 1, `mem_dq_oe` is 0, `rsp_valid` is 0 and `req_ready` is 1.
- R2: A read accepted at clock edge e0 presents the address after e0 with all strobes high. `mem_ce_n` and `mem_oe_n` are then both low, with `mem_we_n` high, for exactly T_ACC consecutive cycles.
- R3: A read's `rsp_rdata` equals the `mem_dq_in` byte present in the last cycle of the read window. `rsp_valid` is high for one cycle, with `rsp_error` 0, in the first cycle after that window (T_ACC+1 edges after e0).
- R4: A write holds `mem_ce_n` and `mem_we_n` low together for exactly T_WP cycles. `mem_oe_n` stays 1 in every cycle of the write.
- R5: `mem_dq_oe` is 1 in every cycle where `mem_we_n` is 0 and in the one cycle after `mem_we_n` rises, so it is high for T_WP+1 cycles in total. `mem_dq_out` carries the request's write data while `mem_dq_oe` is 1.
- R6: `mem_addr` takes the request address one cycle before any strobe falls. It stays unchanged in every cycle where `mem_ce_n` is low.
- R7: After a write, every strobe stays high for at least T_WR cycles after `mem_we_n` rises, and no new cycle begins in that time.
- R8: `req_ready` is 0 from the edge that accepts a request until its recovery ends. It returns to 1 T_ACC+T_WR+1 edges after acceptance for a read and T_WP+T_WR+2 edges after acceptance for a write. A write's `rsp_valid` pulse comes T_WP+2 edges after acceptance.
- R9: A write accepted while `write_protect` is 1 moves no strobe, leaves `mem_dq_oe` at 0 and leaves `mem_addr` unchanged. The next cycle carries `rsp_valid` and `rsp_error` both at 1 and `req_ready` at 1 again.
- R10: `write_protect` has no effect on reads: a read accepted with it high returns the stored byte with `rsp_error` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host offers a request |
| req_ready | output | 1 | Sequencer can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Byte address |
| req_wdata | input | 8 | Write data |
| write_protect | input | 1 | Supervisor write block, sampled at acceptance |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_error | output | 1 | Completion was a refused write |
| rsp_rdata | output | 8 | Read data |
| mem_addr | output | 18 | Memory address bus |
| mem_dq_oe | output | 1 | Drive enable for the data bus |
| mem_dq_out | output | 8 | Data driven onto the bus |
| mem_dq_in | input | 8 | Data read from the bus |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |

## Verification
The bench builds the sequencer with T_ACC=5, T_WP=2 and T_WR=3 instead of the defaults. Each phase length then differs from the others and from its default. A strobe window that is one cycle long or short, or a recovery that reuses the wrong count, shifts a measured cycle number away from its expected value. A recovery of three cycles also leaves room to tell the data-hold cycle after the write pulse apart from the recovery itself.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_READ,
    ST_WPULSE,
    ST_WHOLD,
    ST_RECOV,
    ST_REJECT
  } seq_state_t;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/sram_seq_timer.sv
module sram_seq_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/sram_seq_dpath.sv
module sram_seq_dpath #(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_wdata,
  input  logic              capture,
  input  logic [DATA_W-1:0] bus_in,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic [DATA_W-1:0] rdata_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      if (take) begin
        addr_q  <= in_addr;
        wdata_q <= in_wdata;
      end
      if (capture) begin
        rdata_q <= bus_in;
      end
    end
  end

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_seq_pkg::*;
#(
  parameter int T_ACC = 4,
  parameter int T_WP  = 3,
  parameter int T_WR  = 1,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             write_protect,
  input  logic             tmr_zero,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             take,
  output logic             capture,
  output logic             ready_q,
  output logic             rsp_valid_q,
  output logic             rsp_error_q,
  output logic             ce_n_q,
  output logic             we_n_q,
  output logic             oe_n_q,
  output logic             dq_oe_q
);

  localparam logic [CNT_W-1:0] LD_ACC = CNT_W'(T_ACC - 1);
  localparam logic [CNT_W-1:0] LD_WP  = CNT_W'(T_WP - 1);
  localparam logic [CNT_W-1:0] LD_WR  = CNT_W'(T_WR - 1);

  seq_state_t state_q, state_d;
  logic       is_wr_q;
  logic       accept;
  logic       refuse;

  assign accept  = (state_q == ST_IDLE) && req_valid && ready_q;
  assign refuse  = accept && req_write && write_protect;
  assign take    = accept && !refuse;
  assign capture = (state_q == ST_READ) && tmr_zero;

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (refuse)      state_d = ST_REJECT;
        else if (accept) state_d = ST_SETUP;
      end
      ST_SETUP: begin
        tmr_load = 1'b1;
        if (is_wr_q) begin
          state_d = ST_WPULSE;
          tmr_val = LD_WP;
        end else begin
          state_d = ST_READ;
          tmr_val = LD_ACC;
        end
      end
      ST_READ: begin
        if (tmr_zero) begin
          state_d  = ST_RECOV;
          tmr_load = 1'b1;
          tmr_val  = LD_WR;
        end
      end
      ST_WPULSE: begin
        if (tmr_zero) state_d = ST_WHOLD;
      end
      ST_WHOLD: begin
        state_d  = ST_RECOV;
        tmr_load = 1'b1;
        tmr_val  = LD_WR;
      end
      ST_RECOV: begin
        if (tmr_zero) state_d = ST_IDLE;
      end
      ST_REJECT: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      is_wr_q     <= 1'b0;
      ready_q     <= 1'b1;
      rsp_valid_q <= 1'b0;
      rsp_error_q <= 1'b0;
      ce_n_q      <= 1'b1;
      we_n_q      <= 1'b1;
      oe_n_q      <= 1'b1;
      dq_oe_q     <= 1'b0;
    end else begin
      state_q     <= state_d;
      if (accept) is_wr_q <= req_write;
      ready_q     <= (state_d == ST_IDLE);
      rsp_valid_q <= capture || (state_q == ST_WHOLD) || (state_q == ST_REJECT);
      rsp_error_q <= (state_q == ST_REJECT);
      ce_n_q      <= !((state_d == ST_READ) || (state_d == ST_WPULSE));
      we_n_q      <= !(state_d == ST_WPULSE);
      oe_n_q      <= !(state_d == ST_READ);
      dq_oe_q     <= (state_d == ST_WPULSE) || (state_d == ST_WHOLD);
    end
  end

endmodule

// File: rtl/sram_seq.sv
module sram_seq
  import sram_seq_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 8,
  parameter int T_ACC  = 4,
  parameter int T_WP   = 3,
  parameter int T_WR   = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              write_protect,
  output logic              rsp_valid,
  output logic              rsp_error,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_dq_oe,
  output logic [DATA_W-1:0] mem_dq_out,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n
);

  localparam int T_MAX = max3(T_ACC, T_WP, T_WR);
  localparam int CNT_W = (T_MAX < 2) ? 1 : $clog2(T_MAX);

  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_zero;
  logic             take;
  logic             capture;

  sram_seq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  sram_seq_fsm #(
    .T_ACC (T_ACC),
    .T_WP  (T_WP),
    .T_WR  (T_WR),
    .CNT_W (CNT_W)
  ) u_fsm (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_write     (req_write),
    .write_protect (write_protect),
    .tmr_zero      (tmr_zero),
    .tmr_load      (tmr_load),
    .tmr_val       (tmr_val),
    .take          (take),
    .capture       (capture),
    .ready_q       (req_ready),
    .rsp_valid_q   (rsp_valid),
    .rsp_error_q   (rsp_error),
    .ce_n_q        (mem_ce_n),
    .we_n_q        (mem_we_n),
    .oe_n_q        (mem_oe_n),
    .dq_oe_q       (mem_dq_oe)
  );

  sram_seq_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
    .clk      (clk),
    .rst      (rst),
    .take     (take),
    .in_addr  (req_addr),
    .in_wdata (req_wdata),
    .capture  (capture),
    .bus_in   (mem_dq_in),
    .addr_q   (mem_addr),
    .wdata_q  (mem_dq_out),
    .rdata_q  (rsp_rdata)
  );

endmodule

// File: rtl/sram_seq_checker.sv
module sram_seq_checker #(
  parameter int ADDR_W = 18,
  parameter int T_ACC  = 4,
  parameter int T_WR   = 1
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic              write_protect,
  input logic              rsp_valid,
  input logic              rsp_error,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_dq_oe,
  input logic              mem_ce_n,
  input logic              mem_we_n,
  input logic              mem_oe_n
);

  localparam int HC_W = $clog2(T_ACC + T_WR + 2) + 1;
  localparam logic [HC_W-1:0] HC_MAX = '1;

  logic [HC_W-1:0] we_hi_cnt;
  logic [HC_W-1:0] oe_lo_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      we_hi_cnt <= HC_MAX;
      oe_lo_cnt <= '0;
    end else begin
      if (!mem_we_n)                we_hi_cnt <= '0;
      else if (we_hi_cnt != HC_MAX) we_hi_cnt <= we_hi_cnt + 1'b1;
      if (mem_oe_n)                 oe_lo_cnt <= '0;
      else if (oe_lo_cnt != HC_MAX) oe_lo_cnt <= oe_lo_cnt + 1'b1;
    end
  end

  assert_read_window_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_oe_n) |-> (oe_lo_cnt >= HC_W'(T_ACC)));

  assert_oe_high_in_write_R4: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> (mem_oe_n && !mem_ce_n));

  assert_bus_driven_R5: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> mem_dq_oe);

  assert_bus_hold_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> mem_dq_oe);

  assert_addr_stable_R6: assert property (@(posedge clk) disable iff (rst)
    (!mem_ce_n && !$past(mem_ce_n)) |-> $stable(mem_addr));

  assert_recovery_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_ce_n) |-> (we_hi_cnt >= HC_W'(T_WR)));

  assert_busy_R8: assert property (@(posedge clk) disable iff (rst)
    !mem_ce_n |-> !req_ready);

  assert_refuse_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_write && write_protect) |=>
      (mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe));

  assert_error_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    rsp_error |-> rsp_valid);

endmodule

bind sram_seq sram_seq_checker #(
  .ADDR_W (ADDR_W),
  .T_ACC  (T_ACC),
  .T_WR   (T_WR)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .req_write     (req_write),
  .write_protect (write_protect),
  .rsp_valid     (rsp_valid),
  .rsp_error     (rsp_error),
  .mem_addr      (mem_addr),
  .mem_dq_oe     (mem_dq_oe),
  .mem_ce_n      (mem_ce_n),
  .mem_we_n      (mem_we_n),
  .mem_oe_n      (mem_oe_n)
);

// File: tb/sram_seq_bench.sv
module sram_seq_bench;

  localparam int AW = 18;
  localparam int DW = 8;
  localparam int TA = 5;
  localparam int TP = 2;
  localparam int TR = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic write_protect = 1'b0;
  logic req_ready, rsp_valid, rsp_error;
  logic [DW-1:0] rsp_rdata;
  logic [AW-1:0] mem_addr;
  logic mem_dq_oe;
  logic [DW-1:0] mem_dq_out;
  logic [DW-1:0] mem_dq_in;
  logic mem_ce_n, mem_we_n, mem_oe_n;

  always #10 clk = ~clk;

  sram_seq #(.ADDR_W(AW), .DATA_W(DW), .T_ACC(TA), .T_WP(TP), .T_WR(TR)) u_sram_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .write_protect(write_protect), .rsp_valid(rsp_valid), .rsp_error(rsp_error),
    .rsp_rdata(rsp_rdata), .mem_addr(mem_addr), .mem_dq_oe(mem_dq_oe),
    .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in), .mem_ce_n(mem_ce_n),
    .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n)
  );

  // memory model
  logic [DW-1:0] ram [int];
  logic [DW-1:0] shadow [int];

  always @(posedge clk)
    if (!mem_ce_n && !mem_we_n && mem_dq_oe) ram[int'(mem_addr)] = mem_dq_out;

  always_comb begin
    if (!mem_ce_n && !mem_oe_n && mem_we_n)
      mem_dq_in = ram.exists(int'(mem_addr)) ? ram[int'(mem_addr)] : 8'h00;
    else
      mem_dq_in = 8'hA5;
  end

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  typedef struct { logic [DW-1:0] data; logic err; logic rd; } exp_t;
  exp_t sb [$];

  // monitor: scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && rsp_valid) begin
        if (sb.size() == 0) begin
          check(1'b0, "R3 unexpected response", 1, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(rsp_error == e.err, "R9/R10 rsp_error", int'(rsp_error), int'(e.err));
          if (e.rd) check(rsp_rdata == e.data, "R3 read data", int'(rsp_rdata), int'(e.data));
        end
      end
    end
  end

  task automatic do_req(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input bit wp);
    int n, n_rdy, n_rsp, rd_lo, wr_lo, dq_cnt, bad_oe, bad_addr, bad_data, strobes, last_we;
    logic [AW-1:0] addr_before;
    bit refused;
    exp_t e;
    refused = wr && wp;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    addr_before = mem_addr;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; write_protect = wp;
    e.data = shadow.exists(int'(a)) ? shadow[int'(a)] : 8'h00;
    e.err = refused; e.rd = !wr;
    sb.push_back(e);
    if (wr && !wp) shadow[int'(a)] = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; write_protect = 1'b0;
    n = 1; n_rdy = 0; n_rsp = 0; rd_lo = 0; wr_lo = 0; dq_cnt = 0;
    bad_oe = 0; bad_addr = 0; bad_data = 0; strobes = 0; last_we = 0;
    // R6: address presented before strobes
    if (!refused) check(mem_addr == a && mem_ce_n && mem_oe_n && mem_we_n,
                        "R6 setup", int'(mem_addr), int'(a));
    while (n < 40 && n_rdy == 0) begin
      if (!mem_ce_n && !mem_oe_n && mem_we_n) rd_lo++;
      if (!mem_ce_n && !mem_we_n) begin wr_lo++; last_we = n; end
      if (!mem_we_n && !mem_oe_n) bad_oe++;
      if (!mem_ce_n && mem_addr != a) bad_addr++;
      if (mem_dq_oe) begin dq_cnt++; if (mem_dq_out != d) bad_data++; end
      if (!mem_ce_n || !mem_we_n || !mem_oe_n || mem_dq_oe) strobes++;
      if (rsp_valid && n_rsp == 0) n_rsp = n;
      if (req_ready) n_rdy = n;
      if (n_rdy == 0) begin @(negedge clk); n++; end
    end
    if (refused) begin
      check(strobes == 0, "R9 no strobes", strobes, 0);
      check(mem_addr == addr_before, "R9 addr kept", int'(mem_addr), int'(addr_before));
      check(n_rsp == 2 && n_rdy == 2, "R9 response timing", n_rsp, 2);
    end else if (!wr) begin
      check(rd_lo == TA, "R2 read window", rd_lo, TA);
      check(n_rsp == TA + 2, "R3 response cycle", n_rsp, TA + 2);
      check(n_rdy == TA + TR + 2, "R8 read ready", n_rdy, TA + TR + 2);
      check(bad_addr == 0, "R6 addr stable", bad_addr, 0);
    end else begin
      check(wr_lo == TP, "R4 write pulse", wr_lo, TP);
      check(bad_oe == 0, "R4 oe high", bad_oe, 0);
      check(dq_cnt == TP + 1 && bad_data == 0, "R5 data drive", dq_cnt, TP + 1);
      check(n_rdy - last_we - 1 >= TR, "R7 recovery", n_rdy - last_we - 1, TR);
      check(n_rsp == TP + 3, "R8 write ack", n_rsp, TP + 3);
      check(n_rdy == TP + TR + 3, "R8 write ready", n_rdy, TP + TR + 3);
      check(bad_addr == 0, "R6 addr stable", bad_addr, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    check(mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe && !rsp_valid && req_ready,
          "R1 reset state", 0, 0);
    rst = 1'b0;
    @(negedge clk);
    check(mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe && !rsp_valid && req_ready,
          "R1 after reset", 0, 0);
    do_req(1'b1, 18'h00000, 8'h3C, 1'b0);
    do_req(1'b1, 18'h3FFFF, 8'hC3, 1'b0);
    do_req(1'b1, 18'h12345, 8'hFF, 1'b0);
    do_req(1'b0, 18'h00000, 8'h00, 1'b0);
    do_req(1'b0, 18'h3FFFF, 8'h00, 1'b0);
    do_req(1'b0, 18'h12345, 8'h00, 1'b0);
    do_req(1'b0, 18'h00777, 8'h00, 1'b0);
    // R9: refused write leaves memory intact
    do_req(1'b1, 18'h00000, 8'h99, 1'b1);
    do_req(1'b0, 18'h00000, 8'h00, 1'b0);
    // R10: protect on a read
    do_req(1'b0, 18'h3FFFF, 8'h00, 1'b1);
    for (int i = 0; i < 6; i++) do_req(1'b1, AW'(18'h20000 + i * 3), DW'(8'h11 * i + 1), 1'b0);
    for (int i = 5; i >= 0; i--) do_req(1'b0, AW'(18'h20000 + i * 3), 8'h00, 1'b0);
    repeat (4) @(negedge clk);
    check(sb.size() == 0, "R3 all responses seen", sb.size(), 0);
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule